// File: doc/BRIEF.md
# Repeated String Move Sequencer

This block performs a memory-to-memory copy one element at a time, the way a string move instruction with an optional repeat prefix does. A command carries a source offset, a destination offset, an element size (byte, word or doubleword), a direction flag, an address-size mode (16 or 32 bit), a repeat enable and a repeat count. For each element the sequencer reads from the source offset, writes the returned data unchanged to the destination offset, and steps both offsets by the element size, up or down. In repeat mode it decrements the count after each element and stops when the count reaches zero. At the end it reports the final offsets and count.

Before each element the sequencer checks the segments involved. The source segment is the data segment, or an override segment when the command asks for one. The destination segment is always the extra segment. A null selector, a destination that cannot be written, or an element whose last byte lies past its segment limit raises a fault. The fault stops the copy before that element is read or written.

The controller has seven named states. IDLE accepts a command (transition *accept*). LAUNCH either finishes at once on a zero repeat count (*empty*), goes to FAULT on a failed check (*reject*), or issues the read (*go*). RD_REQ waits for the read to be accepted (*read_taken*). RD_WAIT waits for the read data (*data_back*). WR_REQ waits for the write to be accepted, then either returns to LAUNCH (*next*) or goes to DONE (*last*). DONE and FAULT each last one cycle and return to IDLE (*retire*).

Top module: `strmove_seq`

## Requirements
- R1: After reset, and whenever the block is in IDLE, `cmd_ready` is 1, `done` and `fault` are 0, and `mem_req_valid` is 0. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1.
- R2: Each element is one read request (`mem_we`=0) at the source offset, followed by one write request (`mem_we`=1) at the destination offset. The write data equals the read data returned, and `mem_size` equals the command's size code.
- R3: Size code 0 steps both offsets by 1, code 1 by 2, and codes 2 or 3 by 4. Direction 0 adds the step and direction 1 subtracts it, to both offsets.
- R4: With `cmd_addr16`=1, only bits 15:0 of each offset change, modulo 2^16, and bits 31:16 keep their command values. Memory addresses carry zero in bits 31:16.
- R5: With `cmd_rep`=1 and a nonzero count N, exactly N elements are moved and the final count is 0. With `cmd_rep`=0, exactly one element is moved and the count is returned unchanged.
- R6: With `cmd_rep`=1 and count 0, no memory request is made, `done` pulses without `fault`, and the offsets and count are returned unchanged.
- R7: Read requests show `mem_seg`=2 (override) when `src_ovr_en` was 1 at command time, and `mem_seg`=0 (data) otherwise. Write requests always show `mem_seg`=1 (extra). The source checks use the limit and null flag of the chosen source segment only.
- R8: Any of the following stops the copy before the current element makes any request: a null source selector, a null extra selector, `xseg_writable`=0, or a limit violation. `done` and `fault` then pulse together, and the results hold the offsets and count from before that element.
- R9: An element is out of limit when its effective offset plus its byte count minus one is greater than the segment limit. An element whose last byte equals the limit is allowed.
- R10: `done` is high for exactly one cycle per command, and `fault` is high only while `done` is high.
- R11: At most one memory request is outstanding. A request held without `mem_req_ready` keeps its valid, address and write enable stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_src_off | input | 32 | Starting source offset |
| cmd_dst_off | input | 32 | Starting destination offset |
| cmd_size | input | 2 | Element size code: 0 byte, 1 word, 2/3 doubleword |
| cmd_dir | input | 1 | 0 ascending, 1 descending |
| cmd_addr16 | input | 1 | 1 selects 16-bit offsets |
| cmd_rep | input | 1 | 1 repeats by count |
| cmd_count | input | 32 | Repeat count |
| src_ovr_en | input | 1 | Use the override segment for the source |
| dseg_limit | input | 32 | Data segment limit |
| dseg_null | input | 1 | Data segment selector is null |
| oseg_limit | input | 32 | Override segment limit |
| oseg_null | input | 1 | Override segment selector is null |
| xseg_limit | input | 32 | Extra segment limit |
| xseg_null | input | 1 | Extra segment selector is null |
| xseg_writable | input | 1 | Extra segment may be written |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_seg | output | 2 | Segment: 0 data, 1 extra, 2 override |
| mem_size | output | 2 | Element size code |
| mem_addr | output | 32 | Effective offset |
| mem_wdata | output | 32 | Write data |
| mem_rdata_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Command finished (one cycle) |
| fault | output | 1 | Command stopped by a protection fault |
| res_src_off | output | 32 | Final source offset |
| res_dst_off | output | 32 | Final destination offset |
| res_count | output | 32 | Final count |

## Verification
The assertions check the handshake and pulse rules on every cycle: a one-cycle `done`, `fault` only with `done`, a stalled request held stable, writes only to the extra segment, no request while idle, and zeroed upper address bits in 16-bit mode. The directed scenarios are needed for everything that depends on the command as a whole: the order of addresses across a repeated copy, the step size and direction, 16-bit wrap with the upper bits preserved, override selection, the boundary where the last byte equals the limit, and the results left behind by a fault or by a zero count.

// File: rtl/strmove_pkg.sv
package strmove_pkg;

    typedef enum logic [1:0] {
        SEG_DATA     = 2'd0,
        SEG_EXTRA    = 2'd1,
        SEG_OVERRIDE = 2'd2
    } seg_sel_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        unique case (code)
            2'd0:    elem_bytes = 3'd1;
            2'd1:    elem_bytes = 3'd2;
            default: elem_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/strmove_step.sv
module strmove_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    bytes,
    input  logic          dir,
    input  logic          addr16,
    output logic [AW-1:0] nxt
);
    localparam int LW = 16;

    logic [AW-1:0] wide;
    logic [LW-1:0] narrow;

    always_comb begin
        wide   = dir ? cur - AW'(bytes) : cur + AW'(bytes);
        narrow = dir ? cur[LW-1:0] - LW'(bytes) : cur[LW-1:0] + LW'(bytes);
        nxt    = addr16 ? {cur[AW-1:LW], narrow} : wide;
    end

endmodule

// File: rtl/strmove_guard.sv
module strmove_guard #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] src_eff,
    input  logic [AW-1:0] dst_eff,
    input  logic [2:0]    bytes,
    input  logic [AW-1:0] src_limit,
    input  logic          src_null,
    input  logic [AW-1:0] dst_limit,
    input  logic          dst_null,
    input  logic          dst_writable,
    output logic          flt
);
    localparam int EW = AW + 1;

    logic [EW-1:0] src_last;
    logic [EW-1:0] dst_last;
    logic          src_over;
    logic          dst_over;

    always_comb begin
        src_last = {1'b0, src_eff} + EW'(bytes) - EW'(1);
        dst_last = {1'b0, dst_eff} + EW'(bytes) - EW'(1);
        src_over = src_last > {1'b0, src_limit};
        dst_over = dst_last > {1'b0, dst_limit};
        flt      = src_null | dst_null | ~dst_writable | src_over | dst_over;
    end

endmodule

// File: rtl/strmove_seq.sv
module strmove_seq
    import strmove_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_src_off,
    input  logic [AW-1:0] cmd_dst_off,
    input  logic [1:0]    cmd_size,
    input  logic          cmd_dir,
    input  logic          cmd_addr16,
    input  logic          cmd_rep,
    input  logic [CW-1:0] cmd_count,
    input  logic          src_ovr_en,
    input  logic [AW-1:0] dseg_limit,
    input  logic          dseg_null,
    input  logic [AW-1:0] oseg_limit,
    input  logic          oseg_null,
    input  logic [AW-1:0] xseg_limit,
    input  logic          xseg_null,
    input  logic          xseg_writable,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_we,
    output logic [1:0]    mem_seg,
    output logic [1:0]    mem_size,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rdata_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] res_src_off,
    output logic [AW-1:0] res_dst_off,
    output logic [CW-1:0] res_count
);
    localparam int LW = 16;

    seq_state_t    state_q, state_d;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    size_q;
    logic          dir_q, a16_q, rep_q, ovr_q;
    logic [DW-1:0] data_q;

    logic [2:0]    step_bytes;
    logic [AW-1:0] src_eff, dst_eff, src_nxt, dst_nxt;
    logic          chk_flt;
    logic          last_elem;
    logic          cnt_zero;

    always_comb begin
        step_bytes = elem_bytes(size_q);
        src_eff    = a16_q ? {{(AW-LW){1'b0}}, src_q[LW-1:0]} : src_q;
        dst_eff    = a16_q ? {{(AW-LW){1'b0}}, dst_q[LW-1:0]} : dst_q;
        cnt_zero   = (cnt_q == '0);
        last_elem  = !rep_q || (cnt_q == CW'(1));
    end

    strmove_step #(.AW(AW)) u_src_step (
        .cur(src_q), .bytes(step_bytes), .dir(dir_q), .addr16(a16_q), .nxt(src_nxt)
    );

    strmove_step #(.AW(AW)) u_dst_step (
        .cur(dst_q), .bytes(step_bytes), .dir(dir_q), .addr16(a16_q), .nxt(dst_nxt)
    );

    strmove_guard #(.AW(AW)) u_guard (
        .src_eff(src_eff),
        .dst_eff(dst_eff),
        .bytes(step_bytes),
        .src_limit(ovr_q ? oseg_limit : dseg_limit),
        .src_null(ovr_q ? oseg_null : dseg_null),
        .dst_limit(xseg_limit),
        .dst_null(xseg_null),
        .dst_writable(xseg_writable),
        .flt(chk_flt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = ST_LAUNCH;
            ST_LAUNCH: begin
                if (rep_q && cnt_zero)  state_d = ST_DONE;
                else if (chk_flt)       state_d = ST_FAULT;
                else                    state_d = ST_RD_REQ;
            end
            ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rdata_valid) state_d = ST_WR_REQ;
            ST_WR_REQ:  if (mem_req_ready) state_d = last_elem ? ST_DONE : ST_LAUNCH;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            size_q <= '0;
            dir_q  <= 1'b0;
            a16_q  <= 1'b0;
            rep_q  <= 1'b0;
            ovr_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && cmd_valid) begin
                src_q  <= cmd_src_off;
                dst_q  <= cmd_dst_off;
                cnt_q  <= cmd_count;
                size_q <= cmd_size;
                dir_q  <= cmd_dir;
                a16_q  <= cmd_addr16;
                rep_q  <= cmd_rep;
                ovr_q  <= src_ovr_en;
            end
            if (state_q == ST_RD_WAIT && mem_rdata_valid) data_q <= mem_rdata;
            if (state_q == ST_WR_REQ && mem_req_ready) begin
                src_q <= src_nxt;
                dst_q <= dst_nxt;
                if (rep_q) cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
        mem_we        = (state_q == ST_WR_REQ);
        mem_seg       = mem_we ? SEG_EXTRA : (ovr_q ? SEG_OVERRIDE : SEG_DATA);
        mem_addr      = mem_we ? dst_eff : src_eff;
        mem_size      = size_q;
        mem_wdata     = data_q;
        done          = (state_q == ST_DONE) || (state_q == ST_FAULT);
        fault         = (state_q == ST_FAULT);
        res_src_off   = src_q;
        res_dst_off   = dst_q;
        res_count     = cnt_q;
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_addr) && $stable(mem_we)));
    // R7
    wr_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_we) |-> (mem_seg == 2'd1));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_req_valid && !done));
    // R4
    addr16_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && a16_q) |-> (mem_addr[AW-1:LW] == '0));

endmodule

// File: tb/strmove_seq_test.sv
module strmove_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_src_off = '0, cmd_dst_off = '0, cmd_count = '0;
    logic [1:0]  cmd_size = '0;
    logic        cmd_dir = 1'b0, cmd_addr16 = 1'b0, cmd_rep = 1'b0;
    logic        src_ovr_en = 1'b0;
    logic [31:0] dseg_limit = 32'hFFFF_FFFF, oseg_limit = 32'hFFFF_FFFF, xseg_limit = 32'hFFFF_FFFF;
    logic        dseg_null = 1'b0, oseg_null = 1'b0, xseg_null = 1'b0, xseg_writable = 1'b1;
    logic        mem_req_valid, mem_we;
    logic        mem_req_ready;
    logic [1:0]  mem_seg, mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rdata_valid;
    logic [31:0] mem_rdata;
    logic        done, fault;
    logic [31:0] res_src_off, res_dst_off, res_count;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    strmove_seq uut (.*);

    // memory responder with request log
    logic        rdy_q;
    int          pend;
    logic [31:0] pend_data;
    logic        log_clr = 1'b0;
    int          log_n;
    logic        log_we   [64];
    logic [31:0] log_addr [64];
    logic [1:0]  log_seg  [64];
    logic [1:0]  log_size [64];
    logic [31:0] log_data [64];

    function automatic logic [31:0] pat(input logic [31:0] a);
        pat = {a[7:0] ^ 8'h3C, a[15:8], ~a[7:0], a[7:0] + 8'h11};
    endfunction

    assign mem_req_ready = rdy_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0; pend <= 0; mem_rdata_valid <= 1'b0; mem_rdata <= '0; log_n <= 0;
        end else begin
            rdy_q <= ~rdy_q;
            mem_rdata_valid <= 1'b0;
            if (pend == 1) begin
                mem_rdata_valid <= 1'b1; mem_rdata <= pend_data; pend <= 0;
            end else if (pend > 1) pend <= pend - 1;
            if (log_clr) log_n <= 0;
            else if (mem_req_valid && mem_req_ready && log_n < 64) begin
                log_we[log_n]   <= mem_we;
                log_addr[log_n] <= mem_addr;
                log_seg[log_n]  <= mem_seg;
                log_size[log_n] <= mem_size;
                log_data[log_n] <= mem_wdata;
                log_n <= log_n + 1;
                if (!mem_we) begin pend <= 2; pend_data <= pat(mem_addr); end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        got_fault;
    logic [31:0] got_src, got_dst, got_cnt;

    task automatic run_cmd(input logic [31:0] s, input logic [31:0] d, input logic [1:0] sz,
                           input logic dr, input logic a16, input logic rp, input logic [31:0] n);
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        cmd_src_off = s; cmd_dst_off = d; cmd_size = sz; cmd_dir = dr;
        cmd_addr16 = a16; cmd_rep = rp; cmd_count = n; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int w = 0; w < 2000 && !done; w++) @(negedge clk);
        check("R10 done seen", {31'd0, done}, 32'd1);
        got_fault = fault; got_src = res_src_off; got_dst = res_dst_off; got_cnt = res_count;
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 ready after reset", {31'd0, cmd_ready}, 32'd1);
        check("R1 no request after reset", {31'd0, mem_req_valid}, 32'd0);
        check("R1 done low after reset", {30'd0, done, fault}, 32'd0);
    endtask

    task automatic t_single_byte;
        run_cmd(32'h100, 32'h200, 2'd0, 1'b0, 1'b0, 1'b0, 32'd7);
        check("R5 single element count", log_n, 2);
        check("R2 read first", {31'd0, log_we[0]}, 32'd0);
        check("R2 read addr", log_addr[0], 32'h100);
        check("R7 read seg data", {30'd0, log_seg[0]}, 32'd0);
        check("R2 write addr", log_addr[1], 32'h200);
        check("R2 write data", log_data[1], pat(32'h100));
        check("R2 write size", {30'd0, log_size[1]}, 32'd0);
        check("R7 write seg extra", {30'd0, log_seg[1]}, 32'd1);
        check("R3 byte up src", got_src, 32'h101);
        check("R3 byte up dst", got_dst, 32'h201);
        check("R5 count kept without repeat", got_cnt, 32'd7);
        check("R10 no fault", {31'd0, got_fault}, 32'd0);
    endtask

    task automatic t_rep_word_down;
        run_cmd(32'h1000, 32'h2000, 2'd1, 1'b1, 1'b0, 1'b1, 32'd3);
        check("R5 three elements", log_n, 6);
        check("R3 word down read 2", log_addr[2], 32'h0FFE);
        check("R3 word down read 3", log_addr[4], 32'h0FFC);
        check("R3 word down write 3", log_addr[5], 32'h1FFC);
        check("R2 write data 3", log_data[5], pat(32'h0FFC));
        check("R3 word down src", got_src, 32'h0FFA);
        check("R3 word down dst", got_dst, 32'h1FFA);
        check("R5 count reaches zero", got_cnt, 32'd0);
    endtask

    task automatic t_rep_dword_override;
        src_ovr_en = 1'b1; dseg_null = 1'b1;
        run_cmd(32'h40, 32'h80, 2'd2, 1'b0, 1'b0, 1'b1, 32'd2);
        src_ovr_en = 1'b0; dseg_null = 1'b0;
        check("R7 override ignores data null", {31'd0, got_fault}, 32'd0);
        check("R7 read seg override", {30'd0, log_seg[2]}, 32'd2);
        check("R3 dword up read 2", log_addr[2], 32'h44);
        check("R3 dword up src", got_src, 32'h48);
        check("R3 dword up dst", got_dst, 32'h88);
    endtask

    task automatic t_addr16_wrap;
        run_cmd(32'hABCD_FFFF, 32'h1234_0005, 2'd0, 1'b0, 1'b1, 1'b1, 32'd2);
        check("R4 read addr low", log_addr[0], 32'h0000_FFFF);
        check("R4 read addr wrapped", log_addr[2], 32'h0000_0000);
        check("R4 write addr", log_addr[3], 32'h0000_0006);
        check("R4 src upper kept", got_src, 32'hABCD_0001);
        check("R4 dst", got_dst, 32'h1234_0007);
    endtask

    task automatic t_zero_count;
        run_cmd(32'h300, 32'h400, 2'd1, 1'b0, 1'b0, 1'b1, 32'd0);
        check("R6 no access", log_n, 0);
        check("R6 no fault", {31'd0, got_fault}, 32'd0);
        check("R6 src unchanged", got_src, 32'h300);
        check("R6 count unchanged", got_cnt, 32'd0);
    endtask

    task automatic t_fault_limit;
        xseg_limit = 32'h107;
        run_cmd(32'h10, 32'h100, 2'd2, 1'b0, 1'b0, 1'b1, 32'd3);
        xseg_limit = 32'hFFFF_FFFF;
        check("R9 last byte at limit allowed", log_n, 4);
        check("R8 limit fault", {31'd0, got_fault}, 32'd1);
        check("R8 src before element", got_src, 32'h18);
        check("R8 dst before element", got_dst, 32'h108);
        check("R8 count before element", got_cnt, 32'd1);
    endtask

    task automatic t_fault_nowrite;
        xseg_writable = 1'b0;
        run_cmd(32'h500, 32'h600, 2'd0, 1'b0, 1'b0, 1'b1, 32'd5);
        xseg_writable = 1'b1;
        check("R8 read-only fault", {31'd0, got_fault}, 32'd1);
        check("R8 no access on fault", log_n, 0);
        check("R8 count kept", got_cnt, 32'd5);
        check("R8 dst kept", got_dst, 32'h600);
    endtask

    task automatic t_fault_null;
        dseg_null = 1'b1;
        run_cmd(32'h20, 32'h30, 2'd0, 1'b0, 1'b0, 1'b0, 32'd1);
        dseg_null = 1'b0;
        check("R8 null source fault", {31'd0, got_fault}, 32'd1);
        check("R8 null no access", log_n, 0);
        oseg_limit = 32'h21;
        src_ovr_en = 1'b1;
        run_cmd(32'h20, 32'h30, 2'd1, 1'b0, 1'b0, 1'b0, 32'd1);
        src_ovr_en = 1'b0; oseg_limit = 32'hFFFF_FFFF;
        check("R9 override limit boundary ok", {31'd0, got_fault}, 32'd0);
        check("R1 ready after command", {31'd0, cmd_ready}, 32'd1);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_single_byte();
                t_rep_word_down();
                t_rep_dword_override();
                t_addr16_wrap();
                t_zero_count();
                t_fault_limit();
                t_fault_nowrite();
                t_fault_null();
            end
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=expired expected=finished");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule